// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a register-in, register-out synchronous static RAM. Its word is 36 bits, split into four 9-bit lanes, and its depth is set by an address-width parameter. Address, chip select, global write enable and the four lane write enables are captured on the rising clock edge. Read data passes through an output register, so it appears one full cycle after the address is captured.

Writes are late. The data for a write arrives on the edge after its address and is held in a pending-write register. That register is committed to the array when the next write's data arrives. A read that hits the pending address is served lane by lane from the pending register.

The bus is split into a read-data port and a four-bit lane-drive vector, with one bit per lane that would be tri-stated at a pad. A sleep input moves a four-state controller through RUN, ENTER, DOZE and WAKE:
- RUN goes to ENTER when sleep is high at an edge.
- ENTER goes to DOZE after SLEEP_CYC edges.
- DOZE goes to WAKE when sleep is low at an edge.
- WAKE goes to RUN after SLEEP_CYC edges.

Commands are accepted only in RUN.

Top module: `lwsram_top`

## Requirements
- R1: After reset, lane_drive is 4'b0000 until a read completes.
- R2: A read is cs_n=0 and we_n=1 sampled at edge n while in RUN. After edge n+1, rd_data holds the word at that address, and all four lane_drive bits are 1 while oe_n is 0.
- R3: A write is cs_n=0 and we_n=0 at edge n. Its data is taken from wr_data at edge n+1. Lane i (wr_data bits 9i+8..9i) is updated only when lane_we_n[i] is 0. Lanes whose enable is 1 keep their old contents, even when all four enables are 1.
- R4: A read issued on the cycle right after a write, to the same address, returns the newly written lanes merged over the older contents.
- R5: With cs_n=1 at edge n, no array access takes place, and lane_drive is 0 after edge n+1.
- R6: After edge n+1 following a write captured at edge n, lane_drive is 0 whatever the state of oe_n.
- R7: oe_n=1 forces lane_drive to 0 without waiting for a clock edge. Lowering oe_n restores drive at once while a read result is held.
- R8: Sleep behaviour:
  - Sleep high at an edge forces lane_drive to 0 from that edge on.
  - Commands sampled outside RUN are ignored, and array contents are kept.
  - Entry and recovery each last SLEEP_CYC (default 2) cycles.
  - The first command accepted is the one sampled SLEEP_CYC+1 edges after sleep is sampled low.
- R9: A pending write is moved into the array when a later write's data arrives. After that, the earlier address reads back its data from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled on the edge |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low global write enable |
| lane_we_n | input | LANES | Active-low per-lane write enables, sampled only for writes |
| wr_data | input | LANES*LANE_W | Write data, sampled one edge after the write address |
| oe_n | input | 1 | Active-low output enable, acts combinationally |
| sleep | input | 1 | Active-high sleep request |
| rd_data | output | LANES*LANE_W | Registered read data |
| lane_drive | output | LANES | Per-lane output-enable for the data pads |

## Verification
A vector table exercises several input patterns:
- Reads placed directly after writes, to the same address and to others. These separate pending-register bypass from array reads and show whether a commit happened.
- A partial-lane write and a write with no lanes enabled. These expose mask inversion or lane misplacement.
- Back-to-back writes. These check that the first write is committed when the second write's data arrives.
- Idle (deselect) and write slots. These show whether the drive vector stays low outside reads.

Directed sequences toggle oe_n mid-cycle while a read result is held. Others issue read and write commands during sleep entry and recovery; a later read then shows that those commands were neither executed nor allowed to disturb stored data.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [1:0] {
        SLP_RUN   = 2'd0,
        SLP_ENTER = 2'd1,
        SLP_DOZE  = 2'd2,
        SLP_WAKE  = 2'd3
    } slp_state_t;

endpackage

// File: rtl/lwsram_sleep_fsm.sv
module lwsram_sleep_fsm #(
    parameter int SLEEP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic awake
);
    import lwsram_pkg::*;

    localparam int CNT_W = $clog2(SLEEP_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLEEP_CYC - 1);

    slp_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;

    // state register and dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLP_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != state_d)
                cnt_q <= '0;
            else if (state_q == SLP_ENTER || state_q == SLP_WAKE)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLP_RUN:   if (sleep)          state_d = SLP_ENTER;
            SLP_ENTER: if (cnt_q == LAST)  state_d = SLP_DOZE;
            SLP_DOZE:  if (!sleep)         state_d = SLP_WAKE;
            SLP_WAKE:  if (cnt_q == LAST)  state_d = SLP_RUN;
            default:                       state_d = SLP_RUN;
        endcase
    end

    // outputs
    always_comb begin
        awake = (state_q == SLP_RUN);
    end

endmodule

// File: rtl/lwsram_lane_array.sv
module lwsram_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_word,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l])
                cells[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
        end

        assign rd_word[l*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/lwsram_pend_buf.sv
module lwsram_pend_buf #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic [ADDR_W-1:0]         cap_addr,
    input  logic [LANES*LANE_W-1:0]   cap_word,
    input  logic [LANES-1:0]          cap_mask,
    input  logic [ADDR_W-1:0]         look_addr,
    input  logic [LANES*LANE_W-1:0]   arr_word,
    output logic [LANES*LANE_W-1:0]   merged,
    output logic                      commit,
    output logic [ADDR_W-1:0]         commit_addr,
    output logic [LANES*LANE_W-1:0]   commit_word,
    output logic [LANES-1:0]          commit_mask
);
    logic                     vld_q;
    logic [ADDR_W-1:0]        addr_q;
    logic [LANES*LANE_W-1:0]  word_q;
    logic [LANES-1:0]         mask_q;
    logic                     hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            word_q <= '0;
            mask_q <= '0;
        end else if (cap) begin
            vld_q  <= 1'b1;
            addr_q <= cap_addr;
            word_q <= cap_word;
            mask_q <= cap_mask;
        end
    end

    // older pending entry retires when the next write's data is captured
    assign commit      = cap && vld_q;
    assign commit_addr = addr_q;
    assign commit_word = word_q;
    assign commit_mask = mask_q;

    assign hit = vld_q && (addr_q == look_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] = (hit && mask_q[l]) ?
            word_q[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lwsram_top.sv
module lwsram_top #(
    parameter int ADDR_W    = 10,
    parameter int LANE_W    = 9,
    parameter int LANES     = 4,
    parameter int SLEEP_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      cs_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          lane_we_n,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic                      oe_n,
    input  logic                      sleep,
    output logic [LANES*LANE_W-1:0]   rd_data,
    output logic [LANES-1:0]          lane_drive
);
    localparam int DATA_W = LANES * LANE_W;

    logic                 awake;
    logic                 s1_rd, s1_wr;
    logic [ADDR_W-1:0]    s1_addr;
    logic [LANES-1:0]     s1_mask;
    logic                 out_vld_q;
    logic [DATA_W-1:0]    out_word_q;
    logic [DATA_W-1:0]    arr_word, merged;
    logic                 commit;
    logic [ADDR_W-1:0]    commit_addr;
    logic [DATA_W-1:0]    commit_word;
    logic [LANES-1:0]     commit_mask;

    lwsram_sleep_fsm #(.SLEEP_CYC(SLEEP_CYC)) u_sleep (
        .clk   (clk),
        .rst_n (rst_n),
        .sleep (sleep),
        .awake (awake)
    );

    // command register: commands count only while awake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_rd   <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_mask <= '0;
        end else begin
            s1_rd   <= awake && !cs_n &&  we_n;
            s1_wr   <= awake && !cs_n && !we_n;
            s1_addr <= addr;
            s1_mask <= ~lane_we_n;
        end
    end

    lwsram_pend_buf #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap         (s1_wr),
        .cap_addr    (s1_addr),
        .cap_word    (wr_data),
        .cap_mask    (s1_mask),
        .look_addr   (s1_addr),
        .arr_word    (arr_word),
        .merged      (merged),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_word (commit_word),
        .commit_mask (commit_mask)
    );

    lwsram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_mask (commit_mask),
        .wr_addr (commit_addr),
        .wr_word (commit_word),
        .rd_addr (s1_addr),
        .rd_word (arr_word)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld_q  <= 1'b0;
            out_word_q <= '0;
        end else begin
            out_vld_q <= s1_rd;
            if (s1_rd)
                out_word_q <= merged;
        end
    end

    assign rd_data    = out_word_q;
    assign lane_drive = {LANES{out_vld_q && !oe_n && awake}};

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             sleep,
    input logic             awake,
    input logic [LANES-1:0] lane_drive
);
    AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (lane_drive == '0)); // R7

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && cs_n) |-> ##2 (lane_drive == '0)); // R5

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !cs_n && !we_n) |-> ##2 (lane_drive == '0)); // R6

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !cs_n && we_n) |-> ##2 (lane_drive == {LANES{!oe_n && awake}})); // R2

    AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> (lane_drive == '0)); // R8

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && sleep) |=> !awake); // R8

endmodule

bind lwsram_top lwsram_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .awake      (awake),
    .lane_drive (lane_drive)
);

// File: tb/tb_lwsram_top.sv
module tb_lwsram_top;

    localparam int AW = 10;
    localparam int DW = 36;

    typedef struct packed {
        logic [1:0]    op;    // 0 idle, 1 read, 2 write
        logic [AW-1:0] addr;
        logic [3:0]    wen;   // active-low lane enables
        logic [DW-1:0] data;
        logic [3:0]    tag;   // requirement the output check belongs to
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 10'd5, 4'h0, 36'h1_1111_1111, 4'd6},
        '{2'd1, 10'd5, 4'hF, 36'h0,           4'd4},
        '{2'd0, 10'd0, 4'hF, 36'h0,           4'd5},
        '{2'd2, 10'd9, 4'h0, 36'h2_3456_789A, 4'd6},
        '{2'd1, 10'd5, 4'hF, 36'h0,           4'd9},
        '{2'd0, 10'd0, 4'hF, 36'h0,           4'd5},
        '{2'd2, 10'd5, 4'hA, 36'hF_FFFF_FFFF, 4'd6},
        '{2'd1, 10'd5, 4'hF, 36'h0,           4'd3},
        '{2'd1, 10'd9, 4'hF, 36'h0,           4'd2},
        '{2'd0, 10'd0, 4'hF, 36'h0,           4'd5},
        '{2'd2, 10'd9, 4'hF, 36'h0,           4'd6},
        '{2'd1, 10'd9, 4'hF, 36'h0,           4'd3},
        '{2'd0, 10'd0, 4'hF, 36'h0,           4'd5},
        '{2'd2, 10'd3, 4'h0, 36'h8_0402_0100, 4'd6},
        '{2'd2, 10'd4, 4'h0, 36'h7_6543_210F, 4'd6},
        '{2'd1, 10'd3, 4'hF, 36'h0,           4'd9},
        '{2'd1, 10'd4, 4'hF, 36'h0,           4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs_n, we_n, oe_n, sleep;
    logic [3:0]    lane_we_n;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic [3:0]    lane_drive;

    logic [DW-1:0] mdl_mem [0:(1<<AW)-1];
    logic [DW-1:0] exp_q   [NV];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lwsram_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
        .lane_we_n(lane_we_n), .wr_data(wr_data), .oe_n(oe_n), .sleep(sleep),
        .rd_data(rd_data), .lane_drive(lane_drive)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic mdl_write(input logic [AW-1:0] a, input logic [3:0] wen,
                             input logic [DW-1:0] d);
        for (int l = 0; l < 4; l++)
            if (!wen[l]) mdl_mem[a][l*9 +: 9] = d[l*9 +: 9];
    endtask

    task automatic drive(input logic c, input logic w, input logic [AW-1:0] a,
                         input logic [3:0] m);
        cs_n = c; we_n = w; addr = a; lane_we_n = m;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; wr_data = '0;
        drive(1'b1, 1'b1, '0, 4'hF);
        for (int i = 0; i < (1<<AW); i++) mdl_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1: nothing driven after reset
        chk(lane_drive == 4'h0, "R1 reset drive", 36'(lane_drive), 36'h0);

        // table walk: entry j-2 output checked before entry j is driven
        for (int j = 0; j < NV + 2; j++) begin
            if (j >= 2) begin
                if (VEC[j-2].op == 2'd1) begin
                    chk(lane_drive == 4'hF, tag_name(VEC[j-2].tag), 36'(lane_drive), 36'hF);
                    chk(rd_data == exp_q[j-2], tag_name(VEC[j-2].tag), rd_data, exp_q[j-2]);
                end else begin
                    chk(lane_drive == 4'h0, tag_name(VEC[j-2].tag), 36'(lane_drive), 36'h0);
                end
            end
            wr_data = (j >= 1 && j <= NV && VEC[j-1].op == 2'd2) ? VEC[j-1].data : '0;
            if (j < NV) begin
                case (VEC[j].op)
                    2'd1: begin
                        drive(1'b0, 1'b1, VEC[j].addr, 4'hF);
                        exp_q[j] = mdl_mem[VEC[j].addr];
                    end
                    2'd2: begin
                        drive(1'b0, 1'b0, VEC[j].addr, VEC[j].wen);
                        mdl_write(VEC[j].addr, VEC[j].wen, VEC[j].data);
                        exp_q[j] = '0;
                    end
                    default: begin
                        drive(1'b1, 1'b1, '0, 4'hF);
                        exp_q[j] = '0;
                    end
                endcase
            end else begin
                drive(1'b1, 1'b1, '0, 4'hF);
            end
            tick();
        end

        // R7: output enable gates drive without a clock edge
        drive(1'b0, 1'b1, 10'd9, 4'hF);
        oe_n = 1'b1;
        tick();
        drive(1'b1, 1'b1, '0, 4'hF);
        tick();
        chk(lane_drive == 4'h0, "R7 oe high", 36'(lane_drive), 36'h0);
        oe_n = 1'b0;
        #1;
        chk(lane_drive == 4'hF, "R7 oe low", 36'(lane_drive), 36'hF);
        chk(rd_data == mdl_mem[9], "R7 data", rd_data, mdl_mem[9]);
        tick();

        // R8: sleep entry, ignored commands, recovery
        drive(1'b0, 1'b1, 10'd5, 4'hF);
        tick();
        drive(1'b1, 1'b1, '0, 4'hF);
        sleep = 1'b1;
        tick();
        chk(lane_drive == 4'h0, "R8 entry hiz", 36'(lane_drive), 36'h0);
        drive(1'b0, 1'b0, 10'd5, 4'h0);   // write while entering: ignored
        tick();
        wr_data = '0;
        drive(1'b0, 1'b1, 10'd5, 4'hF);   // read while entering: ignored
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(lane_drive == 4'h0, "R8 asleep hiz", 36'(lane_drive), 36'h0);
        end
        drive(1'b1, 1'b1, '0, 4'hF);
        sleep = 1'b0;
        tick();                           // sleep sampled low: waking
        drive(1'b0, 1'b1, 10'd5, 4'hF);   // read during recovery: ignored
        tick();
        drive(1'b1, 1'b1, '0, 4'hF);
        tick();                           // back to normal operation
        chk(lane_drive == 4'h0, "R8 recovery ignores read", 36'(lane_drive), 36'h0);
        drive(1'b0, 1'b1, 10'd5, 4'hF);
        tick();
        drive(1'b1, 1'b1, '0, 4'hF);
        tick();
        chk(lane_drive == 4'hF, "R8 drive after wake", 36'(lane_drive), 36'hF);
        chk(rd_data == mdl_mem[5], "R8 contents kept", rd_data, mdl_mem[5]);
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule